// File: doc/BRIEF.md
# Event Ring Producer with Host Interrupt

This block sits on the device side of a host link. It places completion and state-change events into a circular ring of slots that the host reads. The ring uses an inverted pointer scheme. The device owns the read pointer: it writes each new event into the slot that pointer names and then steps the pointer forward. The host owns the write pointer and moves it forward to hand consumed slots back to the device. Both sides keep their own copy of both pointers. The host copy of the write pointer reaches this block through a small register write port.

Events arrive on a valid/ready handshake as opaque words. Each accepted event produces a one-cycle slot write strobe, carrying the slot index and the event word, toward the memory transport. After every slot write the block raises a level interrupt, which stays high until the host acknowledges it. Ready is withheld while no slot is free, so an event is never dropped and never overwrites one the host has not yet read. Event formatting and the memory transport itself lie outside this block.

Top module: `evt_ring_producer`

## Requirements
- R1: After reset the read pointer is 0 and the write pointer is RING_LEN-1. Consequently ringIdle=1, evtReady=1, irq=0 and slotWe=0.
- R2: The ring is full when the read pointer equals the write pointer. While full, evtReady is 0 and a waiting event causes no slot write.
- R3: An event is accepted at a clock edge where evtValid and evtReady are both 1. In the following cycle slotWe is 1 for exactly one cycle, slotIdx equals the read pointer at acceptance, and slotData equals the accepted word. The read pointer then advances by one.
- R4: Pointer stepping wraps: the slot after index RING_LEN-1 is index 0.
- R5: ringIdle is 1 exactly when the write pointer plus one, wrapped at RING_LEN, equals the read pointer.
- R6: A host write of the write pointer (hostWpWe=1, index in hostWpData, below RING_LEN) takes effect at that edge. From the next cycle, full, ready and idle follow the new value.
- R7: irq becomes 1 in the cycle after each cycle in which slotWe is 1.
- R8: Once asserted, irq stays 1 until a cycle with irqAck=1 and no slot write. It is 0 in the cycle after that acknowledge.
- R9: If irqAck=1 in the same cycle as a slot write, the new interrupt wins and irq remains 1 in the next cycle.
- R10: While evtValid is 0, no slot write occurs and the read pointer does not move. The next accepted event uses the unchanged index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Event offered |
| evtReady | output | 1 | Event can be accepted (a free slot exists) |
| evtData | input | EVT_W | Opaque event word |
| hostWpWe | input | 1 | Host writes its write pointer |
| hostWpData | input | IDX_W | New write pointer index |
| slotWe | output | 1 | Slot write strobe toward the ring memory |
| slotIdx | output | IDX_W | Slot index being written |
| slotData | output | EVT_W | Event word to store in the slot |
| ringIdle | output | 1 | No events pending for the host |
| irq | output | 1 | Level interrupt to the host |
| irqAck | input | 1 | Host acknowledge of the interrupt |

## Verification
Two functions can land in the same cycle: the host clearing the interrupt, and the block raising it for a fresh slot write. The bench provokes this collision deliberately. It leaves irq asserted, posts a new event, and drives irqAck during exactly the cycle in which slotWe is high. One cycle later irq must still be 1. A separate acknowledge with no write alongside must then clear it. The bench also holds an event against a full ring while the host returns slots, and checks that the event is accepted only after the write pointer update becomes visible.

// File: rtl/evr_pkg.sv
package evr_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic post;   // accept the offered event this cycle
  } evrStrb_t;
endpackage

// File: rtl/evr_dp.sv
module evr_dp
  import evr_pkg::*;
#(
  parameter int RING_LEN = 6,
  parameter int EVT_W    = 32,
  parameter int IDX_W    = $clog2(RING_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  evrStrb_t         strb,
  input  logic [EVT_W-1:0] evtData,
  input  logic             hostWpWe,
  input  logic [IDX_W-1:0] hostWpData,
  output logic             ringFull,
  output logic             ringIdle,
  output logic             slotWe,
  output logic [IDX_W-1:0] slotIdx,
  output logic [EVT_W-1:0] slotData
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_LEN - 1);

  logic [IDX_W-1:0] rdPtr;
  logic [IDX_W-1:0] wrPtr;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] p);
    if (p == LAST_IDX) return '0;
    return p + 1'b1;
  endfunction

  // Inverted tests: equal pointers mean no free slot
  assign ringFull = (rdPtr == wrPtr);
  assign ringIdle = (stepIdx(wrPtr) == rdPtr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= LAST_IDX;
      slotWe   <= 1'b0;
      slotIdx  <= '0;
      slotData <= '0;
    end else begin
      slotWe <= strb.post;
      if (strb.post) begin
        slotIdx  <= rdPtr;
        slotData <= evtData;
        rdPtr    <= stepIdx(rdPtr);
      end
      if (hostWpWe) wrPtr <= hostWpData;
    end
  end

  a_r2_no_post_when_full: assert property (@(posedge clk) disable iff (!rstN)
    strb.post |-> !ringFull);
  a_r3_slot_follows_post: assert property (@(posedge clk) disable iff (!rstN)
    strb.post |=> slotWe && (slotIdx == $past(rdPtr)) && (slotData == $past(evtData)));
  a_r4_ptr_steps_past_slot: assert property (@(posedge clk) disable iff (!rstN)
    slotWe |-> (rdPtr == stepIdx(slotIdx)));
  a_r10_ptr_still_without_post: assert property (@(posedge clk) disable iff (!rstN)
    !strb.post |=> $stable(rdPtr) && !slotWe);
endmodule

// File: rtl/evr_ctrl.sv
module evr_ctrl
  import evr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     evtValid,
  input  logic     ringFull,
  input  logic     slotWe,
  input  logic     irqAck,
  output logic     evtReady,
  output evrStrb_t strb,
  output logic     irq
);
  assign evtReady  = !ringFull;
  assign strb.post = evtValid && !ringFull;

  // A fresh slot write outranks an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)       irq <= 1'b0;
    else if (slotWe) irq <= 1'b1;
    else if (irqAck) irq <= 1'b0;
  end

  a_r7_irq_after_write: assert property (@(posedge clk) disable iff (!rstN)
    slotWe |=> irq);
  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rstN)
    irq && !irqAck |=> irq);
  a_r8_irq_drop_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(irqAck) && !$past(slotWe));
  a_r9_write_beats_ack: assert property (@(posedge clk) disable iff (!rstN)
    slotWe && irqAck |=> irq);
endmodule

// File: rtl/evt_ring_producer.sv
module evt_ring_producer
  import evr_pkg::*;
#(
  parameter int RING_LEN = 6,
  parameter int EVT_W    = 32,
  parameter int IDX_W    = $clog2(RING_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  output logic             evtReady,
  input  logic [EVT_W-1:0] evtData,
  input  logic             hostWpWe,
  input  logic [IDX_W-1:0] hostWpData,
  output logic             slotWe,
  output logic [IDX_W-1:0] slotIdx,
  output logic [EVT_W-1:0] slotData,
  output logic             ringIdle,
  output logic             irq,
  input  logic             irqAck
);
  evrStrb_t strb;
  logic     ringFull;

  evr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evtValid (evtValid),
    .ringFull (ringFull),
    .slotWe   (slotWe),
    .irqAck   (irqAck),
    .evtReady (evtReady),
    .strb     (strb),
    .irq      (irq)
  );

  evr_dp #(.RING_LEN(RING_LEN), .EVT_W(EVT_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .evtData    (evtData),
    .hostWpWe   (hostWpWe),
    .hostWpData (hostWpData),
    .ringFull   (ringFull),
    .ringIdle   (ringIdle),
    .slotWe     (slotWe),
    .slotIdx    (slotIdx),
    .slotData   (slotData)
  );
endmodule

// File: tb/evt_ring_producer_tb.sv
module evt_ring_producer_tb;
  localparam int RING_LEN = 6;
  localparam int EVT_W    = 32;
  localparam int IDX_W    = $clog2(RING_LEN);

  logic             clk = 1'b0;
  logic             rstN;
  logic             evtValid;
  logic             evtReady;
  logic [EVT_W-1:0] evtData;
  logic             hostWpWe;
  logic [IDX_W-1:0] hostWpData;
  logic             slotWe;
  logic [IDX_W-1:0] slotIdx;
  logic [EVT_W-1:0] slotData;
  logic             ringIdle;
  logic             irq;
  logic             irqAck;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  evt_ring_producer #(.RING_LEN(RING_LEN), .EVT_W(EVT_W)) u_dut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtReady(evtReady),
    .evtData(evtData), .hostWpWe(hostWpWe), .hostWpData(hostWpData),
    .slotWe(slotWe), .slotIdx(slotIdx), .slotData(slotData),
    .ringIdle(ringIdle), .irq(irq), .irqAck(irqAck)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Offer one event at a negedge; the ring must have room
  task automatic post_one(input logic [EVT_W-1:0] d, input int expIdx, input string tag);
    evtValid = 1'b1;
    evtData  = d;
    chk(evtReady == 1'b1, {tag, " ready"}, evtReady, 1);
    step();
    evtValid = 1'b0;
    chk(slotWe == 1'b1, {tag, " slotWe"}, slotWe, 1);
    chk(slotIdx == IDX_W'(expIdx), {tag, " slotIdx"}, slotIdx, expIdx);
    chk(slotData == d, {tag, " slotData"}, slotData, d);
  endtask

  task automatic host_wp(input int wp);
    hostWpWe   = 1'b1;
    hostWpData = IDX_W'(wp);
    step();
    hostWpWe   = 1'b0;
  endtask

  task automatic t_reset();
    // R1
    chk(ringIdle == 1'b1, "R1 ringIdle", ringIdle, 1);
    chk(evtReady == 1'b1, "R1 evtReady", evtReady, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(slotWe == 1'b0, "R1 slotWe", slotWe, 0);
  endtask

  task automatic t_fill_and_hold();
    for (int i = 0; i < RING_LEN - 1; i++) post_one(32'hA0 + i, i, "R3 fill");
    step();
    // read pointer 5 equals write pointer 5: full
    chk(evtReady == 1'b0, "R2 full ready", evtReady, 0);
    chk(ringIdle == 1'b0, "R5 full not idle", ringIdle, 0);
    evtValid = 1'b1;
    evtData  = 32'h55;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(slotWe == 1'b0, "R2 held no write", slotWe, 0);
    end
    // Host returns slots while the event waits
    host_wp(2);
    chk(evtReady == 1'b1, "R6 ready after wp write", evtReady, 1);
    step();
    evtValid = 1'b0;
    chk(slotWe == 1'b1, "R6 held event posted", slotWe, 1);
    chk(slotIdx == IDX_W'(5), "R6 held idx", slotIdx, 5);
    chk(slotData == 32'h55, "R6 held data", slotData, 32'h55);
    post_one(32'hB0, 0, "R4 wrap to zero");
  endtask

  task automatic t_idle_test();
    step();
    // read 1, write 2: not idle
    chk(ringIdle == 1'b0, "R5 pending", ringIdle, 0);
    host_wp(0);
    chk(ringIdle == 1'b1, "R5 idle after wp=0", ringIdle, 1);
    chk(evtReady == 1'b1, "R6 ready with wp=0", evtReady, 1);
  endtask

  task automatic t_no_valid();
    evtValid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      evtData = 32'hDEAD0000 + i;
      step();
      chk(slotWe == 1'b0, "R10 no write", slotWe, 0);
    end
    post_one(32'hC1, 1, "R10 index unchanged");
  endtask

  task automatic t_irq();
    step();
    irqAck = 1'b1;
    step();
    irqAck = 1'b0;
    chk(irq == 1'b0, "R8 cleared by ack", irq, 0);
    post_one(32'hC2, 2, "R7 post");
    chk(irq == 1'b0, "R7 not yet", irq, 0);
    step();
    chk(irq == 1'b1, "R7 raised", irq, 1);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(irq == 1'b1, "R8 held", irq, 1);
    end
  endtask

  task automatic t_ack_collision();
    post_one(32'hC3, 3, "R9 post");
    irqAck = 1'b1;   // same cycle as slotWe
    step();
    irqAck = 1'b0;
    chk(irq == 1'b1, "R9 write beats ack", irq, 1);
    irqAck = 1'b1;
    step();
    irqAck = 1'b0;
    chk(irq == 1'b0, "R8 plain ack", irq, 0);
  endtask

  initial begin
    rstN       = 1'b0;
    evtValid   = 1'b0;
    evtData    = '0;
    hostWpWe   = 1'b0;
    hostWpData = '0;
    irqAck     = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_fill_and_hold();
    t_idle_test();
    t_no_valid();
    t_irq();
    t_ack_collision();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule